// File: doc/BRIEF.md
# Clock-Monitor Interrupt Status and Enable Unit

This block is the interrupt front end of a clock-synchronizer control plane. It watches three monitor signals that come from elsewhere in the chip. The first is an external-sync alarm level. The second is the lock flag of a secondary DPLL. The third is a 4-bit index of the best validated input, which comes with its own valid qualifier. From these signals the block raises sticky status flags. Software clears each flag by writing 1 to it.

A second register holds four enable bits. These bits gate four input-validity-change event levels onto a single registered, active-high interrupt request.

Software reaches both registers through a simple address bus with a write strobe and a read strobe. Read data appears one clock after the read strobe.

Each status flag has its own trigger:
- The alarm flag reacts only to a rising edge.
- The lock flag reacts to any edge.
- The unqualified flag reacts when the index field becomes zero while it is valid.

Edge detection compares each signal with a registered copy of it. That copy is primed one cycle after reset, so no event is reported in the first cycle after reset. All monitored signals are assumed to be synchronous to the register clock.

Top module: `clkmon_irq`

## Requirements
- R1: The status register is at address 0x0F and its flags have fixed positions. The alarm flag is bit 7, the lock-change flag is bit 6 and the all-unqualified flag is bit 4. Bits 5 and 3..0 always read 0, and writes to them have no effect.
- R2: The alarm flag sets in the cycle after `sync_alarm_i` goes from 0 to 1. A 1-to-0 change of `sync_alarm_i` leaves the flag unchanged.
- R3: The lock-change flag sets in the cycle after `dpll_lock_i` changes, in either direction.
- R4: The all-unqualified flag sets in the cycle after the condition (`best_vld_i`=1 and `best_idx_i`=0000) becomes true, having been false in the previous cycle.
- R5: Writing 1 to an implemented status bit clears it, and writing 0 to it leaves it unchanged. If a set event and a write-1 clear hit the same bit in the same cycle, the bit stays 1.
- R6: Reset puts the registers in a known state. After reset the status register reads 0xD0, the enable register reads 0x00 and `irq_o` is 0. No change seen during the first clock after reset is reported as an event.
- R7: The enable register is at address 0x10. Enable bits 5, 4, 3 and 2 gate events `vchg_evt_i[3]` (differential input 2), `[2]` (differential input 1), `[1]` (CMOS input 2) and `[0]` (CMOS input 1). Bits 7, 6, 1 and 0 read 0 and ignore writes.
- R8: `irq_o` is 1 in the cycle after any `vchg_evt_i` bit is 1 together with its enable bit, and 0 otherwise.
- R9: When `bus_rd` is 1, `bus_rdata` shows the addressed register on the next cycle. Any address other than 0x0F and 0x10 reads as 0x00, and writes to such addresses change nothing. `bus_rdata` holds its value while `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| sync_alarm_i | input | 1 | External-sync alarm level |
| dpll_lock_i | input | 1 | Secondary DPLL lock flag |
| best_idx_i | input | 4 | Highest-priority validated input index |
| best_vld_i | input | 1 | Index field is valid for this path |
| vchg_evt_i | input | 4 | Input validity-change event levels |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle:
- each detected event sets its flag on the next edge;
- a write-1 clear with no coincident event drops the flag;
- a flag never drops without a clear;
- the interrupt follows the gated events one cycle later;
- unmapped reads return zero.

Other behaviours can only be shown by the bench's scenarios, because they need specific input histories:
- a falling alarm must do nothing;
- an index that goes to zero while invalid only counts once the valid qualifier rises;
- a clear that meets a set in the same cycle must leave the flag at 1;
- a re-applied reset must hide levels that were already high.

// File: rtl/clkmon_irq_pkg.sv
package clkmon_irq_pkg;

    localparam int REG_W = 8;

    localparam int ALARM_BIT = 7;
    localparam int LOCK_BIT  = 6;
    localparam int UNQ_BIT   = 4;

    localparam logic [REG_W-1:0] STS_MASK  = (REG_W'(1) << ALARM_BIT)
                                           | (REG_W'(1) << LOCK_BIT)
                                           | (REG_W'(1) << UNQ_BIT);
    localparam logic [REG_W-1:0] STS_RESET = STS_MASK;

    localparam int ENA_LSB = 2;

    typedef struct packed {
        logic alarm;
        logic lock;
        logic unq;
    } mon_evt_t;

endpackage

// File: rtl/clkmon_edge_detect.sv
module clkmon_edge_detect
    import clkmon_irq_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alarm_i,
    input  logic               lock_i,
    input  logic [FIELD_W-1:0] idx_i,
    input  logic               idx_vld_i,
    output mon_evt_t           set_o
);

    typedef struct packed {
        logic primed;
        logic alarm_prev;
        logic lock_prev;
        logic zero_prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       zero_now;

    always_comb begin
        zero_now         = idx_vld_i && (idx_i == '0);
        st_d.primed      = 1'b1;
        st_d.alarm_prev  = alarm_i;
        st_d.lock_prev   = lock_i;
        st_d.zero_prev   = zero_now;
        set_o.alarm      = st_q.primed && alarm_i && !st_q.alarm_prev;
        set_o.lock       = st_q.primed && (lock_i != st_q.lock_prev);
        set_o.unq        = st_q.primed && zero_now && !st_q.zero_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    alarm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.primed && alarm_i && !$past(alarm_i) |-> set_o.alarm);

    // R3
    lock_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.primed && (lock_i != $past(lock_i)) |-> set_o.lock);

endmodule

// File: rtl/clkmon_status_reg.sv
module clkmon_status_reg
    import clkmon_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mon_evt_t         set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] sts_o
);

    typedef struct packed {
        logic [REG_W-1:0] sts;
    } sts_state_t;

    sts_state_t       st_d, st_q;
    logic [REG_W-1:0] set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[ALARM_BIT] = set_i.alarm;
        set_vec[LOCK_BIT]  = set_i.lock;
        set_vec[UNQ_BIT]   = set_i.unq;
        st_d.sts           = ((st_q.sts & ~(clr_i & STS_MASK)) | set_vec) & STS_MASK;
        sts_o              = st_q.sts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts <= STS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.alarm |=> sts_o[ALARM_BIT]);

    // R4
    unq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.unq |=> sts_o[UNQ_BIT]);

    // R5
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[LOCK_BIT] && !set_i.lock |=> !sts_o[LOCK_BIT]);

    // R5
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o[ALARM_BIT] && !clr_i[ALARM_BIT] |=> sts_o[ALARM_BIT]);

endmodule

// File: rtl/clkmon_irq_gate.sv
module clkmon_irq_gate
    import clkmon_irq_pkg::*;
#(
    parameter int N_EVT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [N_EVT-1:0] evt_i,
    output logic [REG_W-1:0] ena_o,
    output logic             irq_o
);

    localparam int ENA_MSB = ENA_LSB + N_EVT - 1;

    typedef struct packed {
        logic [N_EVT-1:0] ena;
        logic             irq;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (ena_wr_i) begin
            st_d.ena = wdata_i[ENA_MSB:ENA_LSB];
        end
        st_d.irq = |(evt_i & st_q.ena);
        ena_o    = REG_W'(st_q.ena) << ENA_LSB;
        irq_o    = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & ena_o[ENA_MSB:ENA_LSB]) |=> irq_o);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(evt_i & ena_o[ENA_MSB:ENA_LSB])) |=> !irq_o);

endmodule

// File: rtl/clkmon_irq.sv
module clkmon_irq
    import clkmon_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int FIELD_W  = 4,
    parameter int N_EVT    = 4,
    parameter logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(8'h0F),
    parameter logic [ADDR_W-1:0] ENA_ADDR = ADDR_W'(8'h10)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_rd,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               sync_alarm_i,
    input  logic               dpll_lock_i,
    input  logic [FIELD_W-1:0] best_idx_i,
    input  logic               best_vld_i,
    input  logic [N_EVT-1:0]   vchg_evt_i,
    output logic               irq_o
);

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } rd_state_t;

    mon_evt_t         mon_set;
    logic [REG_W-1:0] sts_val;
    logic [REG_W-1:0] ena_val;
    logic [REG_W-1:0] sts_clr;
    logic             ena_wr;
    logic             hit_sts;
    logic             hit_ena;
    rd_state_t        rd_d, rd_q;

    always_comb begin
        hit_sts = (bus_addr == STS_ADDR);
        hit_ena = (bus_addr == ENA_ADDR);
        sts_clr = (bus_wr && hit_sts) ? bus_wdata : '0;
        ena_wr  = bus_wr && hit_ena;
        rd_d    = rd_q;
        if (bus_rd) begin
            rd_d.rdata = hit_sts ? sts_val : (hit_ena ? ena_val : '0);
        end
        bus_rdata = rd_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    clkmon_edge_detect #(.FIELD_W(FIELD_W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_i   (sync_alarm_i),
        .lock_i    (dpll_lock_i),
        .idx_i     (best_idx_i),
        .idx_vld_i (best_vld_i),
        .set_o     (mon_set)
    );

    clkmon_status_reg u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (mon_set),
        .clr_i (sts_clr),
        .sts_o (sts_val)
    );

    clkmon_irq_gate #(.N_EVT(N_EVT)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ena_wr_i (ena_wr),
        .wdata_i  (bus_wdata),
        .evt_i    (vchg_evt_i),
        .ena_o    (ena_val),
        .irq_o    (irq_o)
    );

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !hit_sts && !hit_ena |=> bus_rdata == '0);

    // R1
    sts_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit_sts |=> (bus_rdata & ~STS_MASK) == '0);

endmodule

// File: tb/tb_clkmon_irq.sv
module tb_clkmon_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       sync_alarm_i = 1'b0;
    logic       dpll_lock_i = 1'b0;
    logic [3:0] best_idx_i = 4'd5;
    logic       best_vld_i = 1'b0;
    logic [3:0] vchg_evt_i = '0;
    logic       irq_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    clkmon_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sync_alarm_i(sync_alarm_i), .dpll_lock_i(dpll_lock_i),
        .best_idx_i(best_idx_i), .best_vld_i(best_vld_i),
        .vchg_evt_i(vchg_evt_i), .irq_o(irq_o)
    );

    // Behavioural reference model
    logic [7:0] m_sts = 8'hD0;
    logic [7:0] m_ena = 8'h00;
    logic       m_irq = 1'b0;
    logic [7:0] m_rd  = 8'h00;
    bit         m_primed = 0;
    bit         m_pa = 0, m_pl = 0, m_pz = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts <= 8'hD0; m_ena <= 8'h00; m_irq <= 1'b0; m_rd <= 8'h00;
            m_primed <= 0; m_pa <= 0; m_pl <= 0; m_pz <= 0;
        end else begin
            logic [7:0] set_v, clr_v;
            bit z;
            z = best_vld_i && (best_idx_i == 4'd0);
            set_v = 8'h00;
            if (m_primed) begin
                if (sync_alarm_i && !m_pa) set_v = set_v | 8'h80;
                if (dpll_lock_i != m_pl)   set_v = set_v | 8'h40;
                if (z && !m_pz)            set_v = set_v | 8'h10;
            end
            clr_v = (bus_wr && bus_addr == 8'h0F) ? (bus_wdata & 8'hD0) : 8'h00;
            if (bus_rd)
                m_rd <= (bus_addr == 8'h0F) ? m_sts : ((bus_addr == 8'h10) ? m_ena : 8'h00);
            m_sts <= (m_sts & ~clr_v) | set_v;
            if (bus_wr && bus_addr == 8'h10) m_ena <= bus_wdata & 8'h3C;
            m_irq <= |(vchg_evt_i & m_ena[5:2]);
            m_primed <= 1; m_pa <= sync_alarm_i; m_pl <= dpll_lock_i; m_pz <= z;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 irq vs model", {7'd0, irq_o}, {7'd0, m_irq});
            check("R9 rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R6 reset state
        check("R6 irq after reset", {7'd0, irq_o}, 8'h00);
        rd(8'h0F, 8'hD0, "R6 status reset");
        rd(8'h10, 8'h00, "R6 enable reset");
        // R1 / R5 clear all, reserved stay 0
        wr(8'h0F, 8'hFF);
        rd(8'h0F, 8'h00, "R1 R5 clear all");
        // R2 alarm rising
        @(negedge clk); sync_alarm_i = 1'b1;
        tick(1);
        rd(8'h0F, 8'h80, "R2 alarm rise");
        wr(8'h0F, 8'h80);
        tick(2);
        rd(8'h0F, 8'h00, "R2 alarm held high no reset");
        @(negedge clk); sync_alarm_i = 1'b0;
        tick(2);
        rd(8'h0F, 8'h00, "R2 alarm fall ignored");
        // R3 lock both directions
        @(negedge clk); dpll_lock_i = 1'b1;
        tick(1);
        rd(8'h0F, 8'h40, "R3 lock rise");
        wr(8'h0F, 8'h40);
        rd(8'h0F, 8'h00, "R5 lock cleared");
        @(negedge clk); dpll_lock_i = 1'b0;
        tick(1);
        rd(8'h0F, 8'h40, "R3 lock fall");
        wr(8'h0F, 8'h40);
        // R4 field to zero while valid
        @(negedge clk); best_vld_i = 1'b1; best_idx_i = 4'd5;
        tick(1);
        rd(8'h0F, 8'h00, "R4 nonzero valid no set");
        @(negedge clk); best_idx_i = 4'd0;
        tick(1);
        rd(8'h0F, 8'h10, "R4 field to zero");
        wr(8'h0F, 8'h10);
        @(negedge clk); best_vld_i = 1'b0; best_idx_i = 4'd3;
        @(negedge clk); best_idx_i = 4'd0;
        tick(2);
        rd(8'h0F, 8'h00, "R4 zero while invalid");
        @(negedge clk); best_vld_i = 1'b1;
        tick(1);
        rd(8'h0F, 8'h10, "R4 valid rises on zero");
        wr(8'h0F, 8'h10);
        // R5 set wins over clear, write 0 no effect
        wr(8'h0F, 8'h00);
        @(negedge clk);
        bus_addr = 8'h0F; bus_wdata = 8'h80; bus_wr = 1'b1; sync_alarm_i = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h0F, 8'h80, "R5 set wins");
        wr(8'h0F, 8'h00);
        rd(8'h0F, 8'h80, "R5 write zero no effect");
        wr(8'h0F, 8'h80);
        // R7 enable register
        wr(8'h10, 8'hFF);
        rd(8'h10, 8'h3C, "R7 enable reserved");
        // R8 each event with all enabled
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); vchg_evt_i = 4'(1 << b);
            @(negedge clk);
            check("R8 irq enabled event", {7'd0, irq_o}, 8'h01);
            vchg_evt_i = '0;
            @(negedge clk);
            check("R8 irq drops", {7'd0, irq_o}, 8'h00);
        end
        // R7 mapping: only CMOS input 1 (bit 2)
        wr(8'h10, 8'h04);
        @(negedge clk); vchg_evt_i = 4'b1110;
        @(negedge clk);
        check("R7 masked events", {7'd0, irq_o}, 8'h00);
        vchg_evt_i = 4'b0001;
        @(negedge clk);
        check("R7 enabled bit2 event0", {7'd0, irq_o}, 8'h01);
        vchg_evt_i = '0;
        // R7 differential input 2 (bit 5)
        wr(8'h10, 8'h20);
        @(negedge clk); vchg_evt_i = 4'b1000;
        @(negedge clk);
        check("R7 bit5 event3", {7'd0, irq_o}, 8'h01);
        vchg_evt_i = '0;
        // R9 unmapped address
        wr(8'h33, 8'hFF);
        rd(8'h33, 8'h00, "R9 unmapped read");
        rd(8'h10, 8'h20, "R9 unmapped write ignored");
        tick(3);
        check("R9 rdata held", bus_rdata, 8'h20);
        // R6 reset with levels already high
        @(negedge clk); rst_n = 1'b0; sync_alarm_i = 1'b1; dpll_lock_i = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        wr(8'h0F, 8'hFF);
        tick(2);
        rd(8'h0F, 8'h00, "R6 no event after reset");
        rd(8'h10, 8'h00, "R6 enable reset again");
        tick(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule